// File: doc/BRIEF.md
# Grouped Control-Register Arbiter

This block fronts a bank of memory-mapped control registers split into equal-sized groups. Four requesters can reach the bank: the external-port bus, the program and data core buses, and the I/O bus of the DMA engine. Each requester has its own valid/ready handshake. In every cycle each group serves at most one requester, so requests that target different groups complete side by side. Losers see ready held low until their turn comes.

Requesters are ranked external port first, then program bus, then data bus, then I/O bus. An I/O-bus access occupies its group for several cycles. Once it has started, it keeps the group until it finishes, even if a higher-ranked bus arrives. A write lands in the register file at the end of its cycle, and a read in any later cycle sees it. Each register also drives a copy of itself onto a control output. That copy follows the written value after a delay that depends on the register's class: one class takes two cycles and the other takes three.

Top module: `iop_reg_arbiter`

## Requirements
- R1: In any cycle, at most one requester whose address falls in a given group sees ready high.
- R2: Addresses split as {group[3:2], index[1:0]}. A non-I/O requester that is the only one addressing its group, with no I/O access running there, sees ready in the same cycle it raises valid.
- R3: Within a group the order is external port (requester 0), program bus (1), data bus (2), I/O bus (3). A lower-ranked requester gets no ready while a higher-ranked one is valid on the same group, unless an I/O access is already running there.
- R4: An I/O-bus access takes IO_ACC_CYC cycles (default 2), with ready high only in the last one. Once it has started, no other requester completes in that group until it ends.
- R5: While the external port keeps issuing to a group, the core buses on that group stay held. They are served in the cycle after the external port drops valid.
- R6: A write accepted in cycle T is returned by a read of the same address in cycle T+1.
- R7: For a fast-class register, the control output shows the written value from cycle T+2 on and the old value in T+1.
- R8: Slow-class registers are indices 0, 1, 10 and 11 (mask 0x0C03). For these, the control output shows the old value through T+2 and the new value from T+3.
- R9: Reserved bits [15:12] are stored as zero whatever is written. They read as zero and drive zero on the control outputs.
- R10: After reset every register and control output is zero and every ready is low.
- R11: Ready is low while valid is low. A held requester must keep valid, address and write enable steady until ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 4 | Request valid, one bit per requester |
| req_we_i | input | 4 | Write enable per requester |
| req_addr_i | input | 16 | Register address per requester, 4 bits each |
| req_wdata_i | input | 64 | Write data per requester, 16 bits each |
| req_ready_o | output | 4 | Access completes this cycle |
| req_rdata_o | output | 64 | Read data per requester, valid with ready |
| eff_o | output | 256 | Effective control value of every register, 16 bits each |

## Verification
Several properties are checked on every cycle: the single grant per group, the ranking between the buses, the exclusion around a running I/O access, and the rule that a requester alone on its group passes at once. The same per-cycle checks cover the one-cycle and two-cycle lag from stored value to control output and the clearing of reserved bits. Some behaviour can only be shown by the bench's scenarios. These are the exact completion cycle of each requester across every combination of active requesters and target groups, the core buses waiting out a run of external-port accesses, and an I/O access resisting a late external request. Reading back written patterns and timing the control output against the write cycle also need the bench.

// File: rtl/iop_arb_pkg.sv
package iop_arb_pkg;
  localparam int unsigned NREQ = 4;
  localparam int unsigned RW   = 2;

  typedef enum logic [RW-1:0] {
    REQ_EXT = 2'd0,
    REQ_PM  = 2'd1,
    REQ_DM  = 2'd2,
    REQ_IO  = 2'd3
  } req_e;
endpackage

// File: rtl/iop_eff_pipe.sv
module iop_eff_pipe #(
  parameter int unsigned DW     = 16,
  parameter int unsigned STAGES = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] q_o
);
  logic [DW-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/iop_reg_bank.sv
module iop_reg_bank #(
  parameter int unsigned     RPG       = 4,
  parameter int unsigned     DW        = 16,
  parameter logic [DW-1:0]   RSVD_MASK = 16'hF000,
  parameter logic [RPG-1:0]  SLOW_G    = '0,
  localparam int unsigned    IW        = $clog2(RPG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IW-1:0]     idx_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [RPG*DW-1:0] regs_o,
  output logic [RPG*DW-1:0] eff_o
);
  for (genvar k = 0; k < RPG; k++) begin : g_reg
    logic [DW-1:0] q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         q <= '0;
      else if (we_i && idx_i == IW'(k))    q <= wdata_i & ~RSVD_MASK;
    end

    assign regs_o[k*DW +: DW] = q;

    // fast class: 1 stage (effect in 2nd cycle), slow class: 2 stages
    iop_eff_pipe #(
      .DW    (DW),
      .STAGES(SLOW_G[k] ? 2 : 1)
    ) u_pipe (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (q),
      .q_o   (eff_o[k*DW +: DW])
    );
  end
endmodule

// File: rtl/iop_grp_arb.sv
module iop_grp_arb
  import iop_arb_pkg::*;
#(
  parameter int unsigned  IO_ACC_CYC = 2,
  localparam int unsigned CW         = $clog2(IO_ACC_CYC) + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NREQ-1:0] hit_i,
  output logic [NREQ-1:0] ack_o,
  output req_e            sel_o,
  output logic            lock_o
);
  logic          lock_q;
  logic [CW-1:0] cnt_q;
  logic          any, done;
  req_e          sel;

  always_comb begin
    sel = REQ_EXT;
    any = 1'b0;
    if (lock_q) begin
      sel = REQ_IO;
      any = 1'b1;
    end else begin
      for (int r = 0; r < NREQ; r++) begin
        if (!any && hit_i[r]) begin
          sel = req_e'(r);
          any = 1'b1;
        end
      end
    end
    done = lock_q ? (cnt_q == CW'(IO_ACC_CYC - 1))
                  : (sel != REQ_IO || IO_ACC_CYC == 1);
    ack_o = '0;
    if (any && done) ack_o[sel] = 1'b1;
  end

  // an I/O access, once started, owns the group until its last cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b0;
      cnt_q  <= '0;
    end else if (lock_q) begin
      if (done) begin
        lock_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (any && !done) begin
      lock_q <= 1'b1;
      cnt_q  <= CW'(1);
    end
  end

  assign sel_o  = sel;
  assign lock_o = lock_q;
endmodule

// File: rtl/iop_reg_arbiter.sv
module iop_reg_arbiter
  import iop_arb_pkg::*;
#(
  parameter int unsigned          NGRP       = 4,
  parameter int unsigned          RPG        = 4,
  parameter int unsigned          DW         = 16,
  parameter int unsigned          IO_ACC_CYC = 2,
  parameter logic [DW-1:0]        RSVD_MASK  = 16'hF000,
  parameter logic [NGRP*RPG-1:0]  SLOW_MASK  = 16'h0C03,
  localparam int unsigned         NREG       = NGRP * RPG,
  localparam int unsigned         GW         = $clog2(NGRP),
  localparam int unsigned         IW         = $clog2(RPG),
  localparam int unsigned         AW         = GW + IW
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NREQ-1:0]      req_valid_i,
  input  logic [NREQ-1:0]      req_we_i,
  input  logic [NREQ*AW-1:0]   req_addr_i,
  input  logic [NREQ*DW-1:0]   req_wdata_i,
  output logic [NREQ-1:0]      req_ready_o,
  output logic [NREQ*DW-1:0]   req_rdata_o,
  output logic [NREG*DW-1:0]   eff_o
);
  logic [AW-1:0]     addr_a  [NREQ];
  logic [GW-1:0]     grp_a   [NREQ];
  logic [IW-1:0]     idx_a   [NREQ];
  logic [DW-1:0]     wdata_a [NREQ];
  logic [NREQ-1:0]   ack_g   [NGRP];
  req_e              sel_g   [NGRP];
  logic [NGRP-1:0]   io_lock;
  logic [NREG*DW-1:0] regs_flat;
  logic [NREG*DW-1:0] eff_flat;
  logic [NREQ-1:0]   rdy;

  for (genvar r = 0; r < NREQ; r++) begin : g_req
    assign addr_a[r]  = req_addr_i[r*AW +: AW];
    assign grp_a[r]   = addr_a[r][AW-1:IW];
    assign idx_a[r]   = addr_a[r][IW-1:0];
    assign wdata_a[r] = req_wdata_i[r*DW +: DW];
    assign req_rdata_o[r*DW +: DW] = regs_flat[int'(addr_a[r])*DW +: DW];
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic [NREQ-1:0] hit;
    logic            wr_en;

    for (genvar r = 0; r < NREQ; r++) begin : g_hit
      assign hit[r] = req_valid_i[r] && (grp_a[r] == GW'(g));
    end

    iop_grp_arb #(.IO_ACC_CYC(IO_ACC_CYC)) u_arb (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .hit_i (hit),
      .ack_o (ack_g[g]),
      .sel_o (sel_g[g]),
      .lock_o(io_lock[g])
    );

    assign wr_en = (|ack_g[g]) && req_we_i[sel_g[g]];

    iop_reg_bank #(
      .RPG      (RPG),
      .DW       (DW),
      .RSVD_MASK(RSVD_MASK),
      .SLOW_G   (SLOW_MASK[g*RPG +: RPG])
    ) u_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (wr_en),
      .idx_i  (idx_a[sel_g[g]]),
      .wdata_i(wdata_a[sel_g[g]]),
      .regs_o (regs_flat[g*RPG*DW +: RPG*DW]),
      .eff_o  (eff_flat[g*RPG*DW +: RPG*DW])
    );
  end

  always_comb begin
    rdy = '0;
    for (int g = 0; g < NGRP; g++) rdy = rdy | ack_g[g];
  end

  assign req_ready_o = rdy;
  assign eff_o       = eff_flat;
endmodule

// File: rtl/iop_arb_chk.sv
module iop_arb_chk #(
  parameter int unsigned          NGRP      = 4,
  parameter int unsigned          RPG       = 4,
  parameter int unsigned          DW        = 16,
  parameter logic [DW-1:0]        RSVD_MASK = 16'hF000,
  parameter logic [NGRP*RPG-1:0]  SLOW_MASK = 16'h0C03,
  localparam int unsigned         NREQ      = 4,
  localparam int unsigned         NREG      = NGRP * RPG,
  localparam int unsigned         GW        = $clog2(NGRP),
  localparam int unsigned         IW        = $clog2(RPG),
  localparam int unsigned         AW        = GW + IW
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [NREQ-1:0]     valid_i,
  input logic [NREQ-1:0]     we_i,
  input logic [NREQ*AW-1:0]  addr_i,
  input logic [NREQ*DW-1:0]  wdata_i,
  input logic [NREQ-1:0]     ready_i,
  input logic [NREG*DW-1:0]  regs_i,
  input logic [NREG*DW-1:0]  eff_i,
  input logic [NGRP-1:0]     io_lock_i
);
  logic [GW-1:0] grp [NREQ];
  logic [NREQ-1:0] alone;

  for (genvar r = 0; r < NREQ; r++) begin : g_grp
    assign grp[r] = addr_i[r*AW+IW +: GW];
  end

  always_comb begin
    for (int r = 0; r < NREQ; r++) begin
      alone[r] = 1'b1;
      for (int h = 0; h < NREQ; h++)
        if (h != r && valid_i[h] && grp[h] == grp[r]) alone[r] = 1'b0;
    end
  end

  for (genvar a = 0; a < NREQ; a++) begin : g_pa
    for (genvar b = a + 1; b < NREQ; b++) begin : g_pb
      AST_ONE_PER_GROUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(ready_i[a] && ready_i[b] && grp[a] == grp[b])); // R1
    end
  end

  for (genvar r = 0; r < NREQ; r++) begin : g_rq
    AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i[r] |-> !ready_i[r]); // R11
    AST_HELD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i[r] && !ready_i[r]) |=>
        (valid_i[r] && $stable(addr_i[r*AW +: AW]) && $stable(we_i[r]))); // R11
    if (r < 3) begin : g_core
      AST_ALONE_PASSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i[r] && alone[r] && !io_lock_i[grp[r]]) |-> ready_i[r]); // R2
    end

    logic          wr_q;
    logic [AW-1:0] wa_q;
    logic [DW-1:0] wd_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        wr_q <= 1'b0;
        wa_q <= '0;
        wd_q <= '0;
      end else begin
        wr_q <= ready_i[r] && we_i[r];
        wa_q <= addr_i[r*AW +: AW];
        wd_q <= wdata_i[r*DW +: DW];
      end
    end
    AST_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_q |-> (regs_i[int'(wa_q)*DW +: DW] == (wd_q & ~RSVD_MASK))); // R6
  end

  AST_EXT_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i[0] && !io_lock_i[grp[0]]) |-> ready_i[0]); // R3
  AST_PM_OVER_DM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i[1] && valid_i[2] && grp[1] == grp[2]) |-> !ready_i[2]); // R3
  AST_PM_WAITS_EXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i[0] && valid_i[1] && grp[0] == grp[1]) |-> !ready_i[1]); // R5
  AST_DM_WAITS_EXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i[0] && valid_i[2] && grp[0] == grp[2]) |-> !ready_i[2]); // R5

  for (genvar g = 0; g < NGRP; g++) begin : g_lk
    AST_IO_OWNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      io_lock_i[g] |-> (valid_i[3] && grp[3] == GW'(g))); // R11
    for (genvar r = 0; r < 3; r++) begin : g_ex
      AST_IO_NO_PREEMPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (io_lock_i[g] && grp[r] == GW'(g)) |-> !ready_i[r]); // R4
    end
  end

  for (genvar k = 0; k < NREG; k++) begin : g_eff
    if (SLOW_MASK[k]) begin : g_slow
      AST_SLOW_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        eff_i[k*DW +: DW] == $past(regs_i[k*DW +: DW], 2)); // R8
    end else begin : g_fast
      AST_FAST_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        eff_i[k*DW +: DW] == $past(regs_i[k*DW +: DW])); // R7
    end
    AST_RSVD_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (eff_i[k*DW +: DW] & RSVD_MASK) == '0); // R9
  end
endmodule

bind iop_reg_arbiter iop_arb_chk #(
  .NGRP     (NGRP),
  .RPG      (RPG),
  .DW       (DW),
  .RSVD_MASK(RSVD_MASK),
  .SLOW_MASK(SLOW_MASK)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (req_valid_i),
  .we_i     (req_we_i),
  .addr_i   (req_addr_i),
  .wdata_i  (req_wdata_i),
  .ready_i  (req_ready_o),
  .regs_i   (regs_flat),
  .eff_i    (eff_flat),
  .io_lock_i(io_lock)
);

// File: tb/sim_iop_reg_arbiter.sv
module sim_iop_reg_arbiter;
  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [3:0]   valid = '0;
  logic [3:0]   we = '0;
  logic [15:0]  addr = '0;
  logic [63:0]  wdata = '0;
  logic [3:0]   ready;
  logic [63:0]  rdata;
  logic [255:0] eff;

  int n_chk = 0;
  int n_fail = 0;

  localparam logic [15:0] SLOW = 16'h0C03;
  localparam logic [15:0] KEEP = 16'h0FFF;

  always #10 clk = ~clk;

  iop_reg_arbiter u0 (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .req_valid_i(valid),
    .req_we_i   (we),
    .req_addr_i (addr),
    .req_wdata_i(wdata),
    .req_ready_o(ready),
    .req_rdata_o(rdata),
    .eff_o      (eff)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(input int k, input int pass);
    logic [15:0] kk = 16'(k);
    return (pass == 0) ? (16'hF0A5 ^ (kk * 16'h1111)) : ~(16'h1234 + kk * 16'h0101);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=0 exp=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    #1;
    chk(ready == 4'h0, "R10 ready after reset", 32'(ready), 0);
    chk(eff == '0, "R10 control outputs after reset", 32'(eff[31:0]), 0);
    @(negedge clk);
    valid[0] = 1'b1; addr[3:0] = 4'd7;
    #1;
    chk(ready[0], "R2 lone external read", 32'(ready), 1);
    chk(rdata[15:0] == 16'h0, "R10 register after reset", 32'(rdata[15:0]), 0);
    @(negedge clk);
    valid = '0;

    // sweep: every requester subset x every group assignment
    for (int vm = 0; vm < 16; vm++) begin
      for (int ga = 0; ga < 256; ga++) begin
        int gr [4];
        int expc [4];
        int gotc [4];
        @(negedge clk);
        for (int r = 0; r < 4; r++) begin
          gr[r] = (ga >> (2 * r)) & 3;
          valid[r] = vm[r];
          we[r] = 1'b0;
          addr[r*4 +: 4] = {2'(gr[r]), 2'(r)};
          gotc[r] = 0;
        end
        for (int r = 0; r < 4; r++) begin
          expc[r] = 0;
          for (int h = 0; h <= r; h++)
            if (vm[h] && gr[h] == gr[r]) expc[r] += (h == 3) ? 2 : 1;
        end
        for (int c = 1; c <= 12; c++) begin
          #1;
          for (int r = 0; r < 4; r++)
            if (valid[r] && ready[r] && gotc[r] == 0) gotc[r] = c;
          @(posedge clk);
          @(negedge clk);
          for (int r = 0; r < 4; r++) if (gotc[r] != 0) valid[r] = 1'b0;
          if (valid == 4'h0) break;
        end
        valid = '0;
        for (int r = 0; r < 4; r++)
          if (vm[r]) chk(gotc[r] == expc[r], "R1/R2/R3/R4 completion cycle", 32'(gotc[r]), 32'(expc[r]));
      end
    end

    // R4: a started I/O access is not pre-empted by the external port
    @(negedge clk);
    valid[3] = 1'b1; addr[15:12] = 4'b0100;
    #1;
    chk(!ready[3], "R4 io first cycle", 32'(ready), 0);
    @(negedge clk);
    valid[0] = 1'b1; addr[3:0] = 4'b0101;
    #1;
    chk(ready[3], "R4 io completes", 32'(ready), 32'h8);
    chk(!ready[0], "R4 ext held by running io", 32'(ready), 32'h8);
    @(negedge clk);
    valid[3] = 1'b0;
    #1;
    chk(ready[0], "R4 ext after io", 32'(ready), 1);
    @(negedge clk);
    valid = '0;

    // R5: core waits while the external port keeps streaming to its group
    @(negedge clk);
    valid[0] = 1'b1; addr[3:0] = 4'b1000;
    valid[1] = 1'b1; addr[7:4] = 4'b1011;
    for (int c = 0; c < 3; c++) begin
      #1;
      chk(ready[0] && !ready[1], "R5 core held during ext run", 32'(ready), 1);
      @(negedge clk);
      addr[3:0] = 4'(4'b1000 + c + 1);
      if (c == 2) valid[0] = 1'b0;
    end
    #1;
    chk(ready[1], "R5 core after ext drains", 32'(ready), 2);
    @(negedge clk);
    valid = '0;

    // R6..R9: write, read back, control output timing per class
    for (int pass = 0; pass < 2; pass++) begin
      for (int k = 0; k < 16; k++) begin
        logic [15:0] oldv;
        logic [15:0] nv;
        oldv = (pass == 0) ? 16'h0 : (pat(k, 0) & KEEP);
        nv = pat(k, pass) & KEEP;
        @(negedge clk);
        valid[1] = 1'b1; we[1] = 1'b1; addr[7:4] = 4'(k); wdata[31:16] = pat(k, pass);
        #1;
        chk(ready[1], "R2 write accepted", 32'(ready), 2);
        @(negedge clk);
        valid[1] = 1'b0; we[1] = 1'b0;
        valid[2] = 1'b1; addr[11:8] = 4'(k);
        #1;
        chk(ready[2] && rdata[47:32] == nv, "R6/R9 readback next cycle", 32'(rdata[47:32]), 32'(nv));
        chk(eff[k*16 +: 16] == oldv, "R7/R8 output unchanged in T+1", 32'(eff[k*16 +: 16]), 32'(oldv));
        @(negedge clk);
        valid[2] = 1'b0;
        #1;
        if (SLOW[k])
          chk(eff[k*16 +: 16] == oldv, "R8 slow output still old in T+2", 32'(eff[k*16 +: 16]), 32'(oldv));
        else
          chk(eff[k*16 +: 16] == nv, "R7 fast output new in T+2", 32'(eff[k*16 +: 16]), 32'(nv));
        @(negedge clk);
        #1;
        chk(eff[k*16 +: 16] == nv, "R8/R9 output new by T+3", 32'(eff[k*16 +: 16]), 32'(nv));
      end
    end

    @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule